// File: doc/BRIEF.md
# Decode-Stage Branch Squash Controller

This block settles conditional branches in the decode stage of a five-stage pipeline whose fetch unit always moves on to the next sequential address. Fetching sequentially amounts to betting that every branch falls through. When a branch sits in decode, the block checks its two register operands for equality. It also forms the jump address by adding the branch's PC+4 to the sign-extended offset scaled by four. If the branch is taken, the block steers the next PC to that address and raises `if_flush`.

`if_flush` empties the fetch/decode register on the following edge. The one instruction that was fetched wrongly then reaches execute with every control group cleared, so it can neither touch data memory nor write a register. The block also owns the fetch/decode register and the control-bundle register that leads into execute. A stall request from the hazard unit freezes the fetch/decode register and the PC, and it sends an empty slot forward. A branch that would be taken while a stall is active is held back until the stall clears, which means its operands are valid.

Top module: `brflush_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the fetch/decode register becomes empty (`id_valid`=0, `id_instr`=0), and `ex_ctl` and `ex_valid` become 0.
- R2: `if_flush` and `pc_sel` are 1 exactly when `id_valid`=1, `id_branch`=1, `stall_req`=0 and `id_opnd_a` equals `id_opnd_b` over all XLEN bits.
- R3: `br_target` equals (`id_pc4` + `id_offset`·4) modulo 2^XLEN, where `id_offset` is already sign-extended to XLEN bits.
- R4: On the edge after `if_flush`=1, the fetch/decode register is cleared: `id_valid`=0 and `id_instr`=0.
- R5: The control bundle has the bit layout [8:7] ALU op, [6] ALU source, [5] destination select, [4] branch, [3] memory read, [2] memory write, [1] memory-to-register, [0] register write. A decode slot that is empty is passed to `ex_ctl` as all zeros with `ex_valid`=0, whatever `dec_ctl` holds.
- R6: A branch that is not taken costs no cycle. The following instruction loads into decode on the next edge, and its `dec_ctl` reaches `ex_ctl` one edge after that.
- R7: While `stall_req`=1, `pc_write_en` is 0, the fetch/decode register keeps its contents, and an all-zero `ex_ctl` with `ex_valid`=0 is sent on.
- R8: When a stall and a taken branch coincide, `if_flush` and `pc_sel` stay 0 until `stall_req` falls. They are raised in that cycle, and the branch is still in decode.
- R9: No flush happens when the decode slot is empty or holds a non-branch, even when the two operands are equal.
- R10: A taken branch costs exactly one empty slot. The instruction fetched from `br_target` enters decode on the second edge after the branch entered decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_instr | input | IW | Instruction word from fetch |
| if_pc4 | input | XLEN | PC+4 of the fetched instruction |
| stall_req | input | 1 | Stall request from the hazard unit |
| id_branch | input | 1 | Decoder flags the decode instruction as a conditional branch |
| id_opnd_a | input | XLEN | First branch operand |
| id_opnd_b | input | XLEN | Second branch operand |
| id_offset | input | XLEN | Sign-extended word offset of the branch |
| dec_ctl | input | 9 | Decoded control bundle of the decode instruction |
| pc_sel | output | 1 | 1: next PC is `br_target`, 0: sequential |
| pc_write_en | output | 1 | PC update enable |
| br_target | output | XLEN | Taken-branch address |
| if_flush | output | 1 | Clears the fetch/decode register |
| id_valid | output | 1 | Decode slot holds a live instruction |
| id_instr | output | IW | Instruction in decode |
| id_pc4 | output | XLEN | PC+4 of the instruction in decode |
| ex_ctl | output | 9 | Control bundle entering execute |
| ex_valid | output | 1 | Execute slot holds a live instruction |

## Verification
The bench builds the block with XLEN=6, IW=8 and a comparator chunk width of 4. This makes the last chunk a partial one, so the padded comparator path is exercised. With these values, every pair of operands can be swept: all 4096 equal and unequal combinations. Each pair comes with a different PC+4 and offset, which also covers target wrap-around and negative offsets. Directed sequences cover the taken branch followed by a register-writing and-instruction, the not-taken branch, and a stall that overlaps a taken branch.

// File: rtl/brflush_pkg.sv
// Shared types for the branch squash controller: the control bundle that
// travels with each instruction, split by the stage that consumes it.
package brflush_pkg;
    typedef struct packed {
        logic [1:0] alu_op;
        logic       alu_src;
        logic       reg_dst;
    } ex_grp_t;

    typedef struct packed {
        logic branch;
        logic mem_rd;
        logic mem_wr;
    } m_grp_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_wr;
    } wb_grp_t;

    typedef struct packed {
        ex_grp_t ex;
        m_grp_t  m;
        wb_grp_t wb;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/br_eq_cmp.sv
// Equality comparator for branch operands.
// Splits the operands into CHUNK-bit slices, compares each slice in
// parallel and ANDs the slice results. Assumes W >= 1 and CHUNK >= 1;
// a partial top slice is zero-padded on both sides.
module br_eq_cmp #(
    parameter int W     = 32,
    parameter int CHUNK = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         equal
);
    localparam int NCH = (W + CHUNK - 1) / CHUNK;
    localparam int PW  = NCH * CHUNK;

    logic [PW-1:0]  pad_a;
    logic [PW-1:0]  pad_b;
    logic [NCH-1:0] slice_eq;

    assign pad_a = PW'(opnd_a);
    assign pad_b = PW'(opnd_b);

    for (genvar g = 0; g < NCH; g++) begin : g_slice
        // per-slice compare
        assign slice_eq[g] = (pad_a[g*CHUNK +: CHUNK] == pad_b[g*CHUNK +: CHUNK]);
    end

    assign equal = &slice_eq;
endmodule

// File: rtl/br_target_gen.sv
// Taken-branch address generator: PC+4 plus the sign-extended offset
// scaled to a byte address. Assumes the offset is already sign-extended
// to W bits; the sum wraps modulo 2^W.
module br_target_gen #(
    parameter int W     = 32,
    parameter int SHIFT = 2
) (
    input  logic [W-1:0] pc4,
    input  logic [W-1:0] offset,
    output logic [W-1:0] target
);
    logic [W-1:0] scaled;

    // scale word offset to bytes, then add
    always_comb begin
        scaled = offset << SHIFT;
        target = pc4 + scaled;
    end
endmodule

// File: rtl/ifid_reg.sv
// Fetch/decode pipeline register with hold and clear.
// Hold has priority over clear so that a deferred flush never loses the
// branch still waiting in decode. Synchronous active-low reset.
module ifid_reg #(
    parameter int IW   = 32,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            clear,
    input  logic [IW-1:0]   in_instr,
    input  logic [XLEN-1:0] in_pc4,
    output logic            out_valid,
    output logic [IW-1:0]   out_instr,
    output logic [XLEN-1:0] out_pc4
);
    // capture, hold or squash the decode slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_instr <= '0;
            out_pc4   <= '0;
        end else if (hold) begin
            out_valid <= out_valid;
            out_instr <= out_instr;
            out_pc4   <= out_pc4;
        end else if (clear) begin
            out_valid <= 1'b0;
            out_instr <= '0;
            out_pc4   <= '0;
        end else begin
            out_valid <= 1'b1;
            out_instr <= in_instr;
            out_pc4   <= in_pc4;
        end
    end

    // R4: a flush empties the slot on the next edge
    p_flush_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !hold) |=> (!out_valid && out_instr == '0));

    // R7: a stall freezes the slot
    p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(out_instr) && $stable(out_valid) && $stable(out_pc4)));
endmodule

// File: rtl/idex_ctl_reg.sv
// Decode/execute control register. A killed slot (empty decode slot or
// stall bubble) is sent on as an all-zero bundle so it cannot access
// memory or write a register. Synchronous active-low reset.
module idex_ctl_reg
    import brflush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  ctl_t ctl_in,
    output ctl_t ctl_out,
    output logic valid_out
);
    // forward the bundle or insert a no-op
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            ctl_out   <= '0;
            valid_out <= 1'b0;
        end else begin
            ctl_out   <= ctl_in;
            valid_out <= 1'b1;
        end
    end

    // R5: a killed slot carries no memory or register write into execute
    p_bubble_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!ctl_out.m.mem_wr && !ctl_out.m.mem_rd && !ctl_out.wb.reg_wr && !valid_out));
endmodule

// File: rtl/brflush_ctrl.sv
// Decode-stage branch squash controller for a pipeline that always fetches
// sequentially. Resolves branch equality in decode, selects the target PC
// and flushes the one wrongly fetched instruction. A stall from the hazard
// unit wins over a flush; the flush is issued once the stall drops.
// Assumes operands are valid whenever stall_req is low.
module brflush_ctrl
    import brflush_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IW        = 32,
    parameter int CMP_CHUNK = 8,
    parameter int OFF_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    if_instr,
    input  logic [XLEN-1:0]  if_pc4,
    input  logic             stall_req,
    input  logic             id_branch,
    input  logic [XLEN-1:0]  id_opnd_a,
    input  logic [XLEN-1:0]  id_opnd_b,
    input  logic [XLEN-1:0]  id_offset,
    input  logic [CTL_W-1:0] dec_ctl,
    output logic             pc_sel,
    output logic             pc_write_en,
    output logic [XLEN-1:0]  br_target,
    output logic             if_flush,
    output logic             id_valid,
    output logic [IW-1:0]    id_instr,
    output logic [XLEN-1:0]  id_pc4,
    output logic [CTL_W-1:0] ex_ctl,
    output logic             ex_valid
);
    logic opnd_eq;
    logic take;
    logic slot_kill;
    ctl_t ctl_to_ex;

    br_eq_cmp #(.W(XLEN), .CHUNK(CMP_CHUNK)) u_cmp (
        .opnd_a (id_opnd_a),
        .opnd_b (id_opnd_b),
        .equal  (opnd_eq)
    );

    br_target_gen #(.W(XLEN), .SHIFT(OFF_SHIFT)) u_tgt (
        .pc4    (id_pc4),
        .offset (id_offset),
        .target (br_target)
    );

    // resolve the branch; a stall defers it
    always_comb begin
        take        = id_valid && id_branch && opnd_eq && !stall_req;
        pc_sel      = take;
        if_flush    = take;
        pc_write_en = !stall_req;
        slot_kill   = stall_req || !id_valid;
    end

    ifid_reg #(.IW(IW), .XLEN(XLEN)) u_ifid (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (stall_req),
        .clear     (if_flush),
        .in_instr  (if_instr),
        .in_pc4    (if_pc4),
        .out_valid (id_valid),
        .out_instr (id_instr),
        .out_pc4   (id_pc4)
    );

    assign ctl_to_ex = ctl_t'(dec_ctl);

    idex_ctl_reg u_idex (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (slot_kill),
        .ctl_in    (ctl_to_ex),
        .ctl_out   (ex_ctl),
        .valid_out (ex_valid)
    );

    // R9: only a live branch in decode may flush
    p_flush_needs_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        if_flush |-> (id_valid && id_branch));

    // R8: a stall holds back the flush and the redirect
    p_stall_defers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (!if_flush && !pc_sel));

    // R10: a taken branch leaves exactly one empty slot
    p_one_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (if_flush && !stall_req) |=> (!id_valid ##1 (stall_req || id_valid)));
endmodule

// File: tb/brflush_ctrl_tb_top.sv
module brflush_ctrl_tb_top;
    localparam int XLEN = 6;
    localparam int IW   = 8;
    localparam int CW   = 9;
    localparam logic [CW-1:0] CTL_BR  = 9'b01_0_0_100_00;
    localparam logic [CW-1:0] CTL_AND = 9'b10_0_1_000_01;
    localparam logic [IW-1:0] I_AND   = 8'hA7;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [IW-1:0]   if_instr;
    logic [XLEN-1:0] if_pc4;
    logic            stall_req;
    logic            id_branch;
    logic [XLEN-1:0] id_opnd_a;
    logic [XLEN-1:0] id_opnd_b;
    logic [XLEN-1:0] id_offset;
    logic [CW-1:0]   dec_ctl;
    logic            pc_sel;
    logic            pc_write_en;
    logic [XLEN-1:0] br_target;
    logic            if_flush;
    logic            id_valid;
    logic [IW-1:0]   id_instr;
    logic [XLEN-1:0] id_pc4;
    logic [CW-1:0]   ex_ctl;
    logic            ex_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    brflush_ctrl #(.XLEN(XLEN), .IW(IW), .CMP_CHUNK(4), .OFF_SHIFT(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .if_instr(if_instr), .if_pc4(if_pc4),
        .stall_req(stall_req), .id_branch(id_branch), .id_opnd_a(id_opnd_a),
        .id_opnd_b(id_opnd_b), .id_offset(id_offset), .dec_ctl(dec_ctl),
        .pc_sel(pc_sel), .pc_write_en(pc_write_en), .br_target(br_target),
        .if_flush(if_flush), .id_valid(id_valid), .id_instr(id_instr),
        .id_pc4(id_pc4), .ex_ctl(ex_ctl), .ex_valid(ex_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [IW-1:0] ins, input logic [XLEN-1:0] p4);
        if_instr = ins;
        if_pc4   = p4;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stall_req = 1'b0; id_branch = 1'b0;
        id_opnd_a = '0; id_opnd_b = '0; id_offset = '0; dec_ctl = '0;
        fetch(8'h00, '0);
        repeat (2) @(negedge clk);
        chk("R1 id_valid", 32'(id_valid), 0);
        chk("R1 id_instr", 32'(id_instr), 0);
        chk("R1 ex_ctl", 32'(ex_ctl), 0);
        chk("R1 ex_valid", 32'(ex_valid), 0);
        rst_n = 1'b1;

        // taken branch followed by and-instruction
        fetch(8'hB1, 6'd8);
        @(negedge clk);
        chk("R6 branch in decode", 32'(id_instr), 32'hB1);
        id_branch = 1'b1; id_opnd_a = 6'd5; id_opnd_b = 6'd5; id_offset = 6'd3;
        dec_ctl = CTL_BR; fetch(I_AND, 6'd12);
        #1;
        chk("R2 flush taken", 32'(if_flush), 1);
        chk("R2 pc_sel taken", 32'(pc_sel), 1);
        chk("R3 target", 32'(br_target), 32'd20);
        @(negedge clk);
        chk("R4 slot cleared valid", 32'(id_valid), 0);
        chk("R4 slot cleared instr", 32'(id_instr), 0);
        chk("R6 branch ctl to ex", 32'(ex_ctl), 32'(CTL_BR));
        dec_ctl = CTL_AND; id_opnd_b = 6'd5; fetch(8'hC3, 6'd24);
        #1;
        chk("R9 empty slot no flush", 32'(if_flush), 0);
        @(negedge clk);
        chk("R5 and never writes", 32'(ex_ctl), 0);
        chk("R5 ex_valid bubble", 32'(ex_valid), 0);
        chk("R10 target instr in decode", 32'(id_instr), 32'hC3);
        chk("R10 target valid", 32'(id_valid), 1);

        // not-taken branch
        id_branch = 1'b0; dec_ctl = '0; fetch(8'hB2, 6'd28);
        @(negedge clk);
        id_branch = 1'b1; id_opnd_a = 6'd5; id_opnd_b = 6'd6; dec_ctl = CTL_BR;
        fetch(I_AND, 6'd32);
        #1;
        chk("R6 no flush", 32'(if_flush), 0);
        chk("R6 no redirect", 32'(pc_sel), 0);
        @(negedge clk);
        chk("R6 and loaded", 32'(id_instr), 32'(I_AND));
        chk("R6 and valid", 32'(id_valid), 1);
        id_branch = 1'b0; dec_ctl = CTL_AND; id_opnd_a = 6'd9; id_opnd_b = 6'd9;
        fetch(8'h11, 6'd36);
        #1;
        chk("R9 non-branch equal operands", 32'(if_flush), 0);
        @(negedge clk);
        chk("R6 and ctl reaches ex", 32'(ex_ctl), 32'(CTL_AND));
        chk("R6 and ex_valid", 32'(ex_valid), 1);

        // stall coinciding with a taken branch
        dec_ctl = '0; fetch(8'hB3, 6'd40);
        @(negedge clk);
        id_branch = 1'b1; id_opnd_a = 6'd2; id_opnd_b = 6'd2; id_offset = 6'h3F;
        stall_req = 1'b1; dec_ctl = CTL_BR; fetch(I_AND, 6'd44);
        #1;
        chk("R8 flush deferred", 32'(if_flush), 0);
        chk("R8 redirect deferred", 32'(pc_sel), 0);
        chk("R7 pc frozen", 32'(pc_write_en), 0);
        @(negedge clk);
        chk("R7 decode held", 32'(id_instr), 32'hB3);
        chk("R7 bubble ctl", 32'(ex_ctl), 0);
        chk("R7 bubble valid", 32'(ex_valid), 0);
        stall_req = 1'b0;
        #1;
        chk("R8 flush after stall", 32'(if_flush), 1);
        chk("R3 negative offset", 32'(br_target), 32'd36);
        @(negedge clk);
        chk("R4 cleared after deferred flush", 32'(id_valid), 0);

        // sweep of all operand pairs
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                logic [XLEN-1:0] p4;
                logic [XLEN-1:0] off;
                logic [XLEN-1:0] exp_t;
                p4  = XLEN'(a * 3 + b);
                off = XLEN'(a + 5 * b);
                exp_t = XLEN'(p4 + off * 4);
                id_branch = 1'b0; dec_ctl = '0; fetch(8'hB4, p4);
                @(negedge clk);
                id_branch = 1'b1; id_opnd_a = XLEN'(a); id_opnd_b = XLEN'(b);
                id_offset = off; dec_ctl = CTL_BR;
                #1;
                chk("R2 sweep flush", 32'(if_flush), 32'(a == b));
                chk("R3 sweep target", 32'(br_target), 32'(exp_t));
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule